// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address presented on every beat of a memory read or write burst. A start strobe captures a 9-bit start column together with a burst-length code, an ordering select (sequential or interleaved), a write indication and a write-single-beat mode flag. From the next cycle on, the block drives one column per beat and moves to the following beat on each cycle in which the advance enable is high.

Fixed-length bursts of 1, 2, 4 or 8 beats end by themselves, and the block marks the final beat. A full-page burst steps through all 512 columns, wraps, and keeps going until a stop strobe or a new start ends it. A start strobe is accepted on any cycle, including during a burst, and restarts the sequence from the new column. The surrounding controller uses the column output together with the beat-valid flag to issue column commands and to pace data.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, col_o is 0 and beat_vld_o and last_o are 0.
- R2: A start strobe sampled on a rising edge makes beat_vld_o 1 on the next cycle, with col_o equal to the start column sampled with the strobe.
- R3: The length code gives 0 = one beat, 1 = two, 2 = four, 3 = eight and 7 = full page. Codes 4, 5 and 6, and code 7 with interleaved ordering, give a single beat.
- R4: In sequential ordering, the low log2(length) bits of beat k equal (start + k) modulo the length, and the upper bits keep the start column's value.
- R5: In interleaved ordering (ilv_i = 1), beat k is the start column with its low log2(length) bits XORed with k.
- R6: A full-page burst produces (start + k) modulo 512 on beat k, continues past 512 beats, and never raises last_o.
- R7: last_o is 1 exactly on the final beat of a fixed-length burst. An advance on that beat makes beat_vld_o 0 on the next cycle.
- R8: While adv_i is 0 and no strobe arrives, col_o, beat_vld_o and last_o keep their values.
- R9: A stop strobe without a start makes beat_vld_o 0 on the next cycle. A start during a burst restarts from the new column, and a start wins over a stop in the same cycle.
- R10: When write_i and single_wr_i are both 1 at the start strobe, the burst has one beat whatever the length code. With write_i at 0, the programmed length applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new burst (one-cycle strobe) |
| stop_i | input | 1 | End the burst in progress (one-cycle strobe) |
| adv_i | input | 1 | Move to the next beat on this edge |
| start_col_i | input | 9 | Start column, captured with start_i |
| len_code_i | input | 3 | Burst-length code, captured with start_i |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| write_i | input | 1 | Burst is a write, captured with start_i |
| single_wr_i | input | 1 | Write-single-beat mode flag |
| col_o | output | 9 | Column of the current beat |
| beat_vld_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Current beat is the last of a fixed-length burst |

## Verification
The properties assume the strobes arrive only while reset is low. They also assume the configuration inputs matter only in the cycle of a start strobe, so every check is keyed on the strobe cycle or on the registered outputs. The stimulus drives all inputs half a cycle away from the sampling edge and changes the configuration only together with a start. It holds adv_i at 1 except in the dedicated stall test, so beat timing stays predictable. Bursts are checked beat by beat against an ordering the bench derives from the block-alignment and XOR rules, and include start columns near the top of the column space, where wrapping inside a block and past column 511 can be seen.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int LEN_CODE_W  = 3;
  localparam int MAX_FIX_LOG = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_ONE   = 3'd0,
    LEN_TWO   = 3'd1,
    LEN_FOUR  = 3'd2,
    LEN_EIGHT = 3'd3,
    LEN_PAGE  = 3'd7
  } len_code_e;

endpackage

// File: rtl/bcg_len_decode.sv
// Turns the length code into a low-bit mask (length - 1) and a page flag.
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  write_i,
  input  logic                  single_wr_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  page_o
);

  logic             fixed_ok;
  logic             force_one;
  logic [COL_W-1:0] fix_mask;

  assign force_one = write_i & single_wr_i;
  assign fixed_ok  = (32'(len_code_i) <= MAX_FIX_LOG);

  // bit i of the mask is set when the burst spans 2**(i+1) or more beats
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign fix_mask[i] = (32'(len_code_i) > i);
  end

  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    if (!force_one) begin
      if (len_code_i == LEN_PAGE) begin
        if (!ilv_i) begin
          mask_o = '1;
          page_o = 1'b1;
        end
      end else if (fixed_ok) begin
        mask_o = fix_mask;
      end
    end
  end

endmodule

// File: rtl/bcg_beat_ctr.sv
// Beat index within the burst.
module bcg_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [COL_W-1:0] k_q_o,
  output logic [COL_W-1:0] k_nxt_o
);

  always_comb begin
    if (clear_i)    k_nxt_o = '0;
    else if (inc_i) k_nxt_o = k_q_o + 1'b1;
    else            k_nxt_o = k_q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) k_q_o <= '0;
    else     k_q_o <= k_nxt_o;
  end

endmodule

// File: rtl/bcg_addr_form.sv
// Builds the column of beat k from base column, mask and ordering.
module bcg_addr_form #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] k_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] ilv_xor;

  assign seq_sum = base_i + k_i;
  assign ilv_xor = base_i ^ k_i;

  // carries out of the masked low field are dropped by keeping the base bit
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (ilv_i ? ilv_xor[i] : seq_sum[i]) : base_i[i];
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  adv_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  write_i,
  input  logic                  single_wr_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  beat_vld_o,
  output logic                  last_o
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;

  logic [COL_W-1:0] base_q, base_n;
  logic [COL_W-1:0] mask_q, mask_n;
  logic             ilv_q,  ilv_n;
  logic             page_q, page_n;

  logic [COL_W-1:0] k_q, k_n;
  logic             ctr_inc;
  logic             vld_n;
  logic [COL_W-1:0] col_n;

  bcg_len_decode #(.COL_W(COL_W)) dec_i (
    .len_code_i  (len_code_i),
    .ilv_i       (ilv_i),
    .write_i     (write_i),
    .single_wr_i (single_wr_i),
    .mask_o      (dec_mask),
    .page_o      (dec_page)
  );

  // last_o is high only on the final fixed-length beat
  assign ctr_inc = beat_vld_o & adv_i & ~stop_i & ~last_o;

  bcg_beat_ctr #(.COL_W(COL_W)) ctr_i (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_i),
    .inc_i   (ctr_inc),
    .k_q_o   (k_q),
    .k_nxt_o (k_n)
  );

  always_comb begin
    base_n = start_i ? start_col_i : base_q;
    mask_n = start_i ? dec_mask    : mask_q;
    ilv_n  = start_i ? ilv_i       : ilv_q;
    page_n = start_i ? dec_page    : page_q;

    if (start_i)                       vld_n = 1'b1;
    else if (stop_i)                   vld_n = 1'b0;
    else if (beat_vld_o & adv_i & last_o) vld_n = 1'b0;
    else                               vld_n = beat_vld_o;
  end

  bcg_addr_form #(.COL_W(COL_W)) form_i (
    .base_i (base_n),
    .k_i    (k_n),
    .mask_i (mask_n),
    .ilv_i  (ilv_n),
    .col_o  (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      mask_q     <= '0;
      ilv_q      <= 1'b0;
      page_q     <= 1'b0;
      col_o      <= '0;
      beat_vld_o <= 1'b0;
      last_o     <= 1'b0;
    end else begin
      base_q     <= base_n;
      mask_q     <= mask_n;
      ilv_q      <= ilv_n;
      page_q     <= page_n;
      col_o      <= col_n;
      beat_vld_o <= vld_n;
      last_o     <= vld_n & ~page_n & (k_n == mask_n);
    end
  end

  logic unused_k;
  assign unused_k = ^k_q;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start_i,
  input logic                  stop_i,
  input logic                  adv_i,
  input logic [COL_W-1:0]      start_col_i,
  input logic [LEN_CODE_W-1:0] len_code_i,
  input logic                  ilv_i,
  input logic                  write_i,
  input logic                  single_wr_i,
  input logic [COL_W-1:0]      col_o,
  input logic                  beat_vld_o,
  input logic                  last_o
);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    start_i |=> beat_vld_o && (col_o == $past(start_col_i)));

  a_r7_last_needs_vld: assert property (@(posedge clk) disable iff (rst)
    last_o |-> beat_vld_o);

  a_r7_last_ends: assert property (@(posedge clk) disable iff (rst)
    last_o && adv_i && !start_i && !stop_i |=> !beat_vld_o);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    beat_vld_o && !adv_i && !start_i && !stop_i |=>
      beat_vld_o && $stable(col_o) && $stable(last_o));

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (rst)
    stop_i && !start_i |=> !beat_vld_o);

  a_r6_page_no_last: assert property (@(posedge clk) disable iff (rst)
    start_i && (len_code_i == LEN_PAGE) && !ilv_i && !(write_i && single_wr_i) |=> !last_o);

  a_r10_single_write: assert property (@(posedge clk) disable iff (rst)
    start_i && write_i && single_wr_i |=> last_o);

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .adv_i       (adv_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .ilv_i       (ilv_i),
  .write_i     (write_i),
  .single_wr_i (single_wr_i),
  .col_o       (col_o),
  .beat_vld_o  (beat_vld_o),
  .last_o      (last_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {start col[24:16], code[15:13], ilv[12], write[11], single_wr[10], beats[9:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {9'h005, 3'd0, 1'b0, 1'b0, 1'b0, 10'd1},   // R3 one beat
    {9'h005, 3'd1, 1'b0, 1'b0, 1'b0, 10'd2},   // R4 wrap in pair
    {9'h0A6, 3'd2, 1'b0, 1'b0, 1'b0, 10'd4},   // R4
    {9'h0A6, 3'd3, 1'b0, 1'b0, 1'b0, 10'd8},   // R4
    {9'h1FD, 3'd3, 1'b0, 1'b0, 1'b0, 10'd8},   // R4 top block
    {9'h0A6, 3'd2, 1'b1, 1'b0, 1'b0, 10'd4},   // R5
    {9'h0A5, 3'd3, 1'b1, 1'b0, 1'b0, 10'd8},   // R5
    {9'h033, 3'd1, 1'b1, 1'b0, 1'b0, 10'd2},   // R5
    {9'h033, 3'd3, 1'b0, 1'b1, 1'b1, 10'd1},   // R10 write forced single
    {9'h033, 3'd3, 1'b0, 1'b0, 1'b1, 10'd8},   // R10 read keeps length
    {9'h033, 3'd3, 1'b0, 1'b1, 1'b0, 10'd8},   // R10 write, flag off
    {9'h044, 3'd5, 1'b0, 1'b0, 1'b0, 10'd1},   // R3 reserved code
    {9'h044, 3'd7, 1'b1, 1'b0, 1'b0, 10'd1}    // R3 page + interleave
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, stop_i = 1'b0, adv_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0, write_i = 1'b0, single_wr_i = 1'b0;
  logic [8:0] col_o;
  logic       beat_vld_o, last_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .adv_i(adv_i),
    .start_col_i(start_col_i), .len_code_i(len_code_i), .ilv_i(ilv_i),
    .write_i(write_i), .single_wr_i(single_wr_i),
    .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference ordering: aligned block + offset for sequential, XOR for interleaved
  function automatic int ref_col(int start, int len, bit ilv, int k);
    int base, off;
    if (len > 8) return (start + k) % 512;
    if (ilv) return start ^ k;
    off  = start % len;
    base = start - off;
    return base + ((off + k) % len);
  endfunction

  task automatic launch(input int col, input int code, input bit ilv, input bit wr,
                        input bit sw, input bit stp);
    start_i = 1'b1; stop_i = stp; start_col_i = 9'(col); len_code_i = 3'(code);
    ilv_i = ilv; write_i = wr; single_wr_i = sw; adv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic run_burst(input string tag, input int col, input int code, input bit ilv,
                           input bit wr, input bit sw, input int n);
    launch(col, code, ilv, wr, sw, 1'b0);
    for (int i = 0; i < n; i++) begin
      check({tag, " col"}, col_o, ref_col(col, n, ilv, i));
      check("R7 last", last_o, (i == n - 1));
      check("R2 vld", beat_vld_o, 1);
      @(negedge clk);
    end
    check("R7 end", beat_vld_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 col", col_o, 0);
    check("R1 vld", beat_vld_o, 0);
    check("R1 last", last_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle vld", beat_vld_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_burst((VEC[v][12] ? "R5" : "R4"), int'(VEC[v][24:16]), int'(VEC[v][15:13]),
                VEC[v][12], VEC[v][11], VEC[v][10], int'(VEC[v][9:0]));
    end

    // R6 full page from near the top, past 512 beats
    launch(9'h1FE, 7, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 520; i++) begin
      check("R6 col", col_o, (9'h1FE + i) % 512);
      check("R6 no last", last_o, 0);
      @(negedge clk);
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check("R9 page stopped", beat_vld_o, 0);

    // R8 stall
    launch(9'h010, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 first", col_o, 9'h010);
    adv_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 hold col", col_o, 9'h010);
      check("R8 hold vld", beat_vld_o, 1);
      check("R8 hold last", last_o, 0);
    end
    adv_i = 1'b1;
    @(negedge clk);
    check("R8 resume", col_o, 9'h011);

    // R9 restart mid burst into an interleaved four-beat burst
    launch(9'h0C5, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      check("R9 restart col", col_o, 9'h0C5 ^ i);
      check("R9 restart last", last_o, (i == 3));
      @(negedge clk);
    end
    check("R9 restart end", beat_vld_o, 0);

    // R9 start wins over stop
    launch(9'h100, 1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 start wins", beat_vld_o, 1);
    check("R9 start wins col", col_o, 9'h100);
    @(negedge clk);
    check("R9 second beat", col_o, 9'h101);
    check("R9 second last", last_o, 1);
    @(negedge clk);

    // R9 stop in a fixed burst
    launch(9'h030, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 pre stop", beat_vld_o, 1);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check("R9 stop", beat_vld_o, 0);
    check("R9 stop last", last_o, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule